// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a parallel NOR-style flash store. A host issues write strobes, each with an address and a data word. The sequencer matches these strobes against fixed unlock patterns. A correct three-cycle prefix arms a single word program. A longer six-cycle pattern either starts a sector erase or switches the device into a fast-program mode. In that mode every accepted strobe programs one word and no prefix is needed. Reads go straight to the array at all times, including while an operation is running.

The array behind the sequencer is a behavioural stand-in. A program can only clear bits. An erase sets a whole sector to all ones. Each operation completes a fixed number of clock cycles after it is accepted, and `ready` is low for the whole of that time. A per-sector lock input protects sectors from change. A device reset pin that stays low for a minimum number of clock edges leaves fast-program mode and abandons any operation in progress. Shorter pulses on this pin leave the mode as it is.

Top module: `flash_cmd_seq`

## Requirements
- R1: After `rst_n` is released, `ready` is high, the sequencer is in read mode, every word reads back as all ones, and `rd_data` always shows the stored word at `rd_addr`.
- R2: A normal program takes four accepted writes: data 0xAA at address 0x55, then 0x55 at 0xAA, then 0xA0 at 0x55, then the target address with its data. A lone data write with no prefix changes nothing and does not drop `ready`.
- R3: A write that does not match the expected address or data at any step of a prefix returns the sequencer to read mode. The following writes do not complete the broken sequence, and the array stays unchanged.
- R4: The six writes 0xAA@0x55, 0x55@0xAA, 0x80@0x55, 0xAA@0x55, 0x55@0xAA, 0x20@0x55 enter fast-program mode. After that, one write strobe programs its address with its data.
- R5: In fast-program mode, writes whose data looks like a command (0x30 erase, 0xB0 suspend, 0xAA unlock) are programmed as plain data. They start no erase.
- R6: Only a device reset pulse leaves fast-program mode. To count, the pin must be sampled low on `RST_MIN` consecutive clock edges; a shorter pulse keeps the mode. Writes are ignored while the pin is low.
- R7: The first five writes of R4 followed by data 0x30 at any address in a sector set every word of that sector (address bits [7:6]) to all ones. Words in other sectors are left alone.
- R8: A program or erase aimed at a sector whose `lock_mask` bit is set leaves that sector unchanged and does not drop `ready`.
- R9: `ready` falls after the edge that accepts an operation. It stays low for exactly `PROG_CYCLES` cycles for a program and `ERASE_CYCLES` cycles for an erase. The array shows the new contents in the cycle in which `ready` rises.
- R10: A program stores old AND data; it never sets a bit.
- R11: While `ready` is low, write strobes are ignored. Reads of the target word return the old contents until the operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| reset_pin_n | input | 1 | Device reset pin, active low, filtered by width |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| lock_mask | input | 2**SECT_W | Per-sector write lock, 1 = locked |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Stored word at rd_addr |
| ready | output | 1 | High when no program or erase is running |

## Verification
The assertions watch several rules on every cycle:
- the length of each busy period, counted by an independent counter;
- that no completed operation ever writes a locked sector;
- that a program never sets a bit;
- that no request reaches the array while it is busy;
- that the program state is entered only from the correct prefix step;
- that fast-program mode is left only after a full-width reset pulse;
- that in fast-program mode a write never becomes an erase.

Other behaviours need a chain of events and are shown only by the bench scenarios: aborted prefixes leaving the array unchanged, short reset pulses keeping the mode, command-like data being stored as data, and erase confined to one sector.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    CS_READ,
    CS_UNL1,
    CS_UNL2,
    CS_PGM,
    CS_EXT1,
    CS_EXT2,
    CS_EXT3
  } cmd_state_e;

  localparam logic [7:0] CD_UNL_A = 8'hAA;
  localparam logic [7:0] CD_UNL_B = 8'h55;
  localparam logic [7:0] CD_PGM   = 8'hA0;
  localparam logic [7:0] CD_EXT   = 8'h80;
  localparam logic [7:0] CD_ERS   = 8'h30;
  localparam logic [7:0] CD_BYP   = 8'h20;

endpackage

// File: rtl/flash_rst_filter.sv
module flash_rst_filter #(
  parameter int RST_MIN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic long_rst
);
  localparam int CNT_W = $clog2(RST_MIN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_MIN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RST_MIN);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || pin_n) low_cnt <= '0;
    else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
  end

  assign long_rst = !pin_n && (low_cnt == LAST);

  // one clear pulse per low period (R6)
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    long_rst |=> !long_rst);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR1 = 'h55,
  parameter logic [ADDR_W-1:0] CMD_ADDR2 = 'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_mode,
  output logic              req_prog,
  output logic              req_erase,
  output logic              bypass_mode
);
  cmd_state_e st, st_nxt;
  logic byp_set;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                               input logic [ADDR_W-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == DATA_W'(ed));
  endfunction

  always_comb begin
    st_nxt    = st;
    req_prog  = 1'b0;
    req_erase = 1'b0;
    byp_set   = 1'b0;
    if (wr_en) begin
      if (bypass_mode) begin
        req_prog = 1'b1;
        st_nxt   = CS_READ;
      end else begin
        unique case (st)
          CS_READ: st_nxt = hit(wr_addr, wr_data, CMD_ADDR1, CD_UNL_A) ? CS_UNL1 : CS_READ;
          CS_UNL1: st_nxt = hit(wr_addr, wr_data, CMD_ADDR2, CD_UNL_B) ? CS_UNL2 : CS_READ;
          CS_UNL2: begin
            if (hit(wr_addr, wr_data, CMD_ADDR1, CD_PGM))      st_nxt = CS_PGM;
            else if (hit(wr_addr, wr_data, CMD_ADDR1, CD_EXT)) st_nxt = CS_EXT1;
            else                                               st_nxt = CS_READ;
          end
          CS_PGM: begin
            req_prog = 1'b1;
            st_nxt   = CS_READ;
          end
          CS_EXT1: st_nxt = hit(wr_addr, wr_data, CMD_ADDR1, CD_UNL_A) ? CS_EXT2 : CS_READ;
          CS_EXT2: st_nxt = hit(wr_addr, wr_data, CMD_ADDR2, CD_UNL_B) ? CS_EXT3 : CS_READ;
          CS_EXT3: begin
            if (wr_data == DATA_W'(CD_ERS))                    req_erase = 1'b1;
            else if (hit(wr_addr, wr_data, CMD_ADDR1, CD_BYP)) byp_set   = 1'b1;
            st_nxt = CS_READ;
          end
          default: st_nxt = CS_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_mode) begin
      st          <= CS_READ;
      bypass_mode <= 1'b0;
    end else begin
      st <= st_nxt;
      if (byp_set) bypass_mode <= 1'b1;
    end
  end

  // program state reached only from the third prefix step (R2)
  assert_pgm_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == CS_PGM) |-> $past(st) == CS_UNL2);

  // in fast-program mode nothing becomes an erase (R5)
  assert_bypass_no_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_mode && wr_en) |-> !req_erase);

  // mode left only after a full-width reset pulse (R6)
  assert_bypass_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_mode) |-> $past(clr_mode));

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int SECT_W       = 2,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   abort,
  input  logic                   req_prog,
  input  logic                   req_erase,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_data,
  input  logic [(1<<SECT_W)-1:0] lock_mask,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXD  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int DLY_W = $clog2(MAXD + 1);

  function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  function automatic logic [DATA_W-1:0] clear_only(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic              op_erase;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DLY_W-1:0]  dly;
  logic              lock_hit, accept, done;

  assign lock_hit = (req_prog || req_erase) && lock_mask[sect_of(req_addr)];
  assign accept   = (req_prog || req_erase) && !busy && !lock_hit;
  assign done     = busy && (dly == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      busy     <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      dly      <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      op_erase <= req_erase;
      op_addr  <= req_addr;
      op_data  <= req_data;
      dly      <= req_erase ? DLY_W'(ERASE_CYCLES - 1) : DLY_W'(PROG_CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      dly <= dly - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (done && !abort) begin
      if (op_erase) begin
        for (int i = 0; i < DEPTH; i++)
          if (sect_of(ADDR_W'(i)) == sect_of(op_addr)) mem[i] <= '1;
      end else begin
        mem[op_addr] <= clear_only(mem[op_addr], op_data);
      end
    end
  end

  assign rd_data = mem[rd_addr];

  // checker state
  logic [DLY_W-1:0]  chk_run;
  logic              chk_prog_q;
  logic [ADDR_W-1:0] chk_addr;
  logic [DATA_W-1:0] chk_old;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) chk_run <= '0;
    else                 chk_run <= chk_run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_prog_q <= 1'b0;
      chk_addr   <= '0;
      chk_old    <= '0;
    end else begin
      chk_prog_q <= done && !op_erase && !abort;
      chk_addr   <= op_addr;
      chk_old    <= mem[op_addr];
    end
  end

  // busy period length (R9)
  assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> chk_run == (op_erase ? DLY_W'(ERASE_CYCLES - 1) : DLY_W'(PROG_CYCLES - 1)));

  // no completed operation touches a locked sector (R8)
  assert_lock_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lock_mask[sect_of(op_addr)]);

  // a program only clears bits (R10)
  assert_clear_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_prog_q |-> (mem[chk_addr] & ~chk_old) == '0);

  // no request reaches a busy array (R11)
  assert_no_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(req_prog || req_erase));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int SECT_W       = 2,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12,
  parameter int RST_MIN      = 5,
  parameter logic [ADDR_W-1:0] CMD_ADDR1 = 'h55,
  parameter logic [ADDR_W-1:0] CMD_ADDR2 = 'hAA
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reset_pin_n,
  input  logic                   wr_stb,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [(1<<SECT_W)-1:0] lock_mask,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   ready
);
  logic busy, long_rst, wr_en, req_prog, req_erase, bypass_mode;

  assign wr_en = wr_stb && !busy && reset_pin_n;
  assign ready = !busy;

  flash_rst_filter #(.RST_MIN(RST_MIN)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_n    (reset_pin_n),
    .long_rst (long_rst)
  );

  flash_cmd_decoder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR1(CMD_ADDR1), .CMD_ADDR2(CMD_ADDR2)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .clr_mode    (long_rst),
    .req_prog    (req_prog),
    .req_erase   (req_erase),
    .bypass_mode (bypass_mode)
  );

  flash_array_model #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (long_rst),
    .req_prog  (req_prog),
    .req_erase (req_erase),
    .req_addr  (wr_addr),
    .req_data  (wr_data),
    .lock_mask (lock_mask),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (busy)
  );

  // writes are ignored while the reset pin is low (R6)
  assert_pin_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_pin_n |-> !(req_prog || req_erase));

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int PROG  = 6;
  localparam int ERASE = 12;
  localparam int RMIN  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_pin_n = 1'b1;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  lock_mask = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ready;

  int checks = 0;
  int errors = 0;
  int run = 0;
  int exp_q[$];
  logic [15:0] model [256];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_seq #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE), .RST_MIN(RMIN)) dut (
    .clk(clk), .rst_n(rst_n), .reset_pin_n(reset_pin_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .lock_mask(lock_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
  );

  // monitor: measures each busy period and pops the expected length
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ready) run++;
      else if (run > 0) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected busy period: actual %0d expected none", run);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (run != e) begin
            errors++;
            $display("FAIL R9 busy length: actual %0d expected %0d", run, e);
          end
        end
        run = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic prefix3(input logic [7:0] code);
    wr(8'h55, 16'h00AA); wr(8'hAA, 16'h0055); wr(8'h55, {8'h00, code});
  endtask

  task automatic expect_prog(input logic [7:0] a, input logic [15:0] d);
    model[a] = model[a] & d;
    exp_q.push_back(PROG);
  endtask

  task automatic expect_erase(input logic [7:0] a);
    for (int i = 0; i < 256; i++)
      if (i[7:6] == a[7:6]) model[i] = 16'hFFFF;
    exp_q.push_back(ERASE);
  endtask

  task automatic erase_seq(input logic [7:0] a);
    prefix3(8'h80);
    wr(8'h55, 16'h00AA); wr(8'hAA, 16'h0055); wr(a, 16'h0030);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_rd(input logic [7:0] a, input string tag);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== model[a]) begin
      errors++;
      $display("FAIL %s addr %h: actual %h expected %h", tag, a, rd_data, model[a]);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pin_pulse(input int n);
    @(negedge clk);
    reset_pin_n = 1'b0;
    repeat (n) @(negedge clk);
    reset_pin_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_bit(ready, 1'b1, "R1 ready after reset");
    chk_rd(8'h10, "R1 erased after reset");
    chk_rd(8'hC4, "R1 erased after reset");

    // R2 normal program
    prefix3(8'hA0); wr(8'h10, 16'h1234); expect_prog(8'h10, 16'h1234);
    wait_ready();
    chk_rd(8'h10, "R2 three-cycle program");
    wr(8'h11, 16'h0000);
    wait_ready();
    chk_rd(8'h11, "R2 lone write ignored");

    // R3 broken sequences
    wr(8'h55, 16'h00AA); wr(8'hAA, 16'h0055); wr(8'h55, 16'h0077);
    wr(8'h55, 16'h00A0); wr(8'h12, 16'h0000);
    wait_ready();
    chk_rd(8'h12, "R3 wrong data aborts");
    wr(8'h55, 16'h00AA); wr(8'h56, 16'h0055); wr(8'h55, 16'h00A0);
    wr(8'h12, 16'h0000);
    wait_ready();
    chk_rd(8'h12, "R3 wrong address aborts");

    // R10 clear-only
    prefix3(8'hA0); wr(8'h10, 16'hFF0F); expect_prog(8'h10, 16'hFF0F);
    wait_ready();
    chk_rd(8'h10, "R10 bits only cleared");
    prefix3(8'hA0); wr(8'h13, 16'h00FF); expect_prog(8'h13, 16'h00FF);
    wait_ready();
    chk_rd(8'h13, "R10 program fresh word");

    // R11 busy behaviour
    prefix3(8'hA0); wr(8'h14, 16'h5A5A);
    chk_bit(ready, 1'b0, "R11 ready low after accept");
    chk_rd(8'h14, "R11 old data while busy");
    expect_prog(8'h14, 16'h5A5A);
    wr(8'h15, 16'h0000);
    wait_ready();
    chk_rd(8'h14, "R11 program completes");
    chk_rd(8'h15, "R11 write while busy ignored");

    // R8 lockout
    prefix3(8'hA0); wr(8'hC4, 16'h0F0F); expect_prog(8'hC4, 16'h0F0F);
    wait_ready();
    lock_mask = 4'b1000;
    erase_seq(8'hC0);
    wait_ready();
    chk_rd(8'hC4, "R8 locked erase");
    prefix3(8'hA0); wr(8'hC4, 16'h00F0);
    wait_ready();
    chk_rd(8'hC4, "R8 locked program");

    // R7 sector erase
    erase_seq(8'h20); expect_erase(8'h20);
    wait_ready();
    chk_rd(8'h10, "R7 sector erased");
    chk_rd(8'h14, "R7 sector erased");
    chk_rd(8'hC4, "R7 other sector kept");

    // R4 fast-program mode
    prefix3(8'h80);
    wr(8'h55, 16'h00AA); wr(8'hAA, 16'h0055); wr(8'h55, 16'h0020);
    wr(8'h50, 16'hABCD); expect_prog(8'h50, 16'hABCD);
    wait_ready();
    chk_rd(8'h50, "R4 single-write program");

    // R5 command-like data stored as data
    wr(8'h20, 16'h0030); expect_prog(8'h20, 16'h0030);
    wait_ready();
    chk_rd(8'h20, "R5 erase code stored");
    chk_rd(8'h10, "R5 no erase started");
    wr(8'h21, 16'h00B0); expect_prog(8'h21, 16'h00B0);
    wait_ready();
    chk_rd(8'h21, "R5 suspend code stored");
    wr(8'h55, 16'h00AA); expect_prog(8'h55, 16'h00AA);
    wait_ready();
    chk_rd(8'h55, "R5 unlock code stored");

    // R6 reset pin width
    pin_pulse(RMIN - 2);
    wr(8'h22, 16'h1111); expect_prog(8'h22, 16'h1111);
    wait_ready();
    chk_rd(8'h22, "R6 short pulse keeps mode");
    pin_pulse(RMIN);
    wr(8'h23, 16'h0000);
    wait_ready();
    chk_rd(8'h23, "R6 long pulse leaves mode");
    prefix3(8'hA0); wr(8'h23, 16'h2222); expect_prog(8'h23, 16'h2222);
    wait_ready();
    chk_rd(8'h23, "R6 normal program after exit");

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing busy periods: actual %0d expected 0", exp_q.size());
    end
    chk_bit(ready, 1'b1, "R9 idle at end");
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule